// File: doc/BRIEF.md
# DDR3 Module Timing and Capacity Decoder

This block watches a byte-wide configuration stream read from a DDR3 module's presence-detect memory. Every cycle in which `valid_i` is high presents one byte and its address. The block keeps only the ten addresses it needs and ignores the rest. An `end_i` pulse closes the stream. The block then derives three results:

- the minimum clock period in picoseconds, built from a medium timebase ratio, a fine timebase ratio and a signed fine correction;
- the set of supported CAS latencies;
- the module capacity in MiB, taken from three log-encoded fields.

The arithmetic runs over roughly ninety cycles. A single shift-add multiplier and a single restoring divider are shared across the steps. When the results are ready, `done_o` rises. The results and `done_o` then hold until the next accepted `end_i`.

A boot-time configuration engine typically uses the block as follows. It streams the presence-detect bytes in any order, pulses `end_i`, and waits for `done_o` before it programs the memory controller. If `err_o` is set, the results should not be trusted. The cause can be a zero divisor, an impossible capacity encoding, or a byte that never arrived.

Top module: `ddr3_cfg_decoder`

## Requirements
- R1: While `rst_ni` is low and after its release, `done_o` and `err_o` are 0 and `tck_ps_o`, `cas_map_o` and `cap_mib_o` are 0 until a stream completes.
- R2: A byte is captured when `valid_i` is high and `addr_i` is one of 4, 7, 8, 9, 10, 11, 12, 14, 15 or 34. A later write to the same address overrides an earlier one, and writes to any other address change no result.
- R3: `tck_ps_o` (signed) equals trunc(b12·1000·b10 / b11) + trunc0(s34·b9[7:4] / b9[3:0]). Here bN is the byte at address N, s34 is byte 34 read as two's complement, and trunc0 rounds toward zero.
- R4: If b9[3:0] is 0 or b11 is 0, `err_o` is 1 and `tck_ps_o` is 0.
- R5: `cas_map_o` equals {b15[6:0], b14}, so bit i means CAS latency i+4 is supported.
- R6: Let e = b8[2:0] − b7[2:0] + b4[3:0] + 6. When e ≥ 0, `cap_mib_o` equals 2^e·(b7[5:3]+1).
- R7: When e < 0, `cap_mib_o` is 0 and `err_o` is 1.
- R8: Any of the ten addresses not written since the stream began reads as 0 in R3–R6 and forces `err_o` to 1.
- R9: After an accepted `end_i`, `done_o` drops at the next clock edge. It rises within 128 cycles and then holds, together with stable outputs, until the next accepted `end_i`. While the computation is in progress, `valid_i` and `end_i` are ignored.
- R10: Completion empties the captured set, so the next stream starts with every address unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the presented byte |
| data_i | input | 8 | Byte value |
| valid_i | input | 1 | Byte strobe |
| end_i | input | 1 | End-of-stream pulse; starts the computation |
| tck_ps_o | output | 28 | Signed minimum clock period in ps |
| cas_map_o | output | 15 | Supported CAS latency bitmap, bit i = CL i+4 |
| cap_mib_o | output | 32 | Module capacity in MiB |
| err_o | output | 1 | Zero divisor, negative capacity exponent or missing byte |
| done_o | output | 1 | Results valid |

## Verification
The bench targets a negative fine correction whose quotient is not whole. A design that floors instead of truncating toward zero would be off by one there. It drives an all-zero stream, which would expose stale bytes carried over from the previous stream. It also uses the largest operands with the most negative correction, where a narrow product would wrap. Zero divisors in either ratio, the single negative capacity exponent, repeated writes to one address, and a byte plus a second end pulse injected mid-computation round out the directed cases. A design that let any of these through would show a wrong period, a missing error flag, or a result taken from the injected byte.

// File: rtl/ddr3_dec_pkg.sv
package ddr3_dec_pkg;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 10;
  localparam int unsigned PROD_W     = 26;  // 255*1000*255 < 2^26
  localparam int unsigned TCK_W      = 28;
  localparam int unsigned CAP_W      = 32;
  localparam int unsigned CAS_W      = 15;
  localparam int unsigned NS_TO_PS   = 1000;
  localparam int unsigned EXP_W      = 7;

  localparam int unsigned IDX_DENS    = 0;
  localparam int unsigned IDX_ORG     = 1;
  localparam int unsigned IDX_BUSW    = 2;
  localparam int unsigned IDX_FTB     = 3;
  localparam int unsigned IDX_MTB_DVD = 4;
  localparam int unsigned IDX_MTB_DVS = 5;
  localparam int unsigned IDX_TCK     = 6;
  localparam int unsigned IDX_CAS_LO  = 7;
  localparam int unsigned IDX_CAS_HI  = 8;
  localparam int unsigned IDX_FINE    = 9;

  function automatic logic [ADDR_W-1:0] field_addr(input int unsigned idx);
    case (idx)
      IDX_DENS:    return ADDR_W'(4);
      IDX_ORG:     return ADDR_W'(7);
      IDX_BUSW:    return ADDR_W'(8);
      IDX_FTB:     return ADDR_W'(9);
      IDX_MTB_DVD: return ADDR_W'(10);
      IDX_MTB_DVS: return ADDR_W'(11);
      IDX_TCK:     return ADDR_W'(12);
      IDX_CAS_LO:  return ADDR_W'(14);
      IDX_CAS_HI:  return ADDR_W'(15);
      IDX_FINE:    return ADDR_W'(34);
      default:     return '1;
    endcase
  endfunction

  typedef enum logic [2:0] {
    S_IDLE, S_MUL_NS, S_MUL_MTB, S_DIV_MTB, S_MUL_FTB, S_DIV_FTB, S_FIN
  } seq_state_e;
endpackage

// File: rtl/ddr3_byte_capture.sv
module ddr3_byte_capture
  import ddr3_dec_pkg::*;
#(
  parameter int unsigned N = NUM_FIELDS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        clr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BYTE_W-1:0]           data_i,
  output logic [N-1:0][BYTE_W-1:0]    bytes_o,
  output logic [N-1:0]                seen_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = field_addr(g);
    logic [BYTE_W-1:0] val_q;
    logic              seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q  <= '0;
        seen_q <= 1'b0;
      end else if (clr_i) begin
        val_q  <= '0;
        seen_q <= 1'b0;
      end else if (we_i && addr_i == SLOT_ADDR) begin
        val_q  <= data_i;
        seen_q <= 1'b1;
      end
    end

    assign bytes_o[g] = val_q;
    assign seen_o[g]  = seen_q;
  end

  assert_clear_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (seen_o == '0 && bytes_o == '0));
endmodule

// File: rtl/ddr3_serial_mul.sv
module ddr3_serial_mul #(
  parameter int unsigned AW = 26,
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] p_o
);
  localparam int unsigned CNT_W = $clog2(BW + 1);

  logic [AW-1:0]    acc_q, ma_q;
  logic [BW-1:0]    mb_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      ma_q   <= '0;
      mb_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q  <= '0;
        ma_q   <= a_i;
        mb_q   <= b_i;
        cnt_q  <= CNT_W'(BW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (mb_q[0]) acc_q <= acc_q + ma_q;
        ma_q  <= ma_q << 1;
        mb_q  <= mb_q >> 1;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign p_o    = acc_q;

  assert_mul_idle_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  assert_mul_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
endmodule

// File: rtl/ddr3_serial_div.sv
module ddr3_serial_div #(
  parameter int unsigned NW = 26,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] n_i,
  input  logic [DW-1:0] d_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NW-1:0] q_o
);
  localparam int unsigned CNT_W = $clog2(NW + 1);

  logic [NW-1:0]    q_q;
  logic [DW-1:0]    r_q, dv_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DW:0]      trial, diff;
  logic             ge;

  assign trial = {r_q, q_q[NW-1]};
  assign ge    = trial >= {1'b0, dv_q};
  assign diff  = trial - {1'b0, dv_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      dv_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q    <= n_i;
        r_q    <= '0;
        dv_q   <= d_i;
        cnt_q  <= CNT_W'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        r_q   <= ge ? diff[DW-1:0] : trial[DW-1:0];
        q_q   <= {q_q[NW-2:0], ge};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign q_o    = q_q;

  assert_div_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> d_i != '0);
  assert_div_rem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> r_q < dv_q);
endmodule

// File: rtl/ddr3_tck_seq.sv
module ddr3_tck_seq
  import ddr3_dec_pkg::*;
#(
  parameter int unsigned PW = PROD_W,
  parameter int unsigned TW = TCK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic [BYTE_W-1:0]    tck_mtb_i,
  input  logic [BYTE_W-1:0]    fine_i,
  input  logic [BYTE_W-1:0]    ftb_i,
  input  logic [BYTE_W-1:0]    mtb_dvd_i,
  input  logic [BYTE_W-1:0]    mtb_dvs_i,
  output logic                 busy_o,
  output logic                 fin_o,
  output logic                 div_ok_o,
  output logic signed [TW-1:0] tck_o
);
  localparam int unsigned NIB = BYTE_W / 2;

  seq_state_e         state_q;
  logic               launched_q;
  logic [PW-1:0]      t1_q;
  logic signed [TW-1:0] tck_q;

  logic               mul_start, mul_busy, mul_done;
  logic               div_start, div_busy, div_done;
  logic [PW-1:0]      mul_a, mul_p, div_q;
  logic [BYTE_W-1:0]  mul_b, div_d, fine_mag;
  logic signed [TW-1:0] t1_s, q2_s;

  assign div_ok_o = (ftb_i[NIB-1:0] != '0) && (mtb_dvs_i != '0);
  assign fine_mag = fine_i[BYTE_W-1] ? (~fine_i + BYTE_W'(1)) : fine_i;

  assign mul_start = !launched_q &&
    (state_q == S_MUL_NS || state_q == S_MUL_MTB || state_q == S_MUL_FTB);
  assign div_start = !launched_q && (state_q == S_DIV_MTB || state_q == S_DIV_FTB);

  always_comb begin
    mul_a = PW'(NS_TO_PS);
    mul_b = tck_mtb_i;
    if (state_q == S_MUL_MTB) begin
      mul_a = mul_p;
      mul_b = mtb_dvd_i;
    end else if (state_q == S_MUL_FTB) begin
      mul_a = PW'(fine_mag);
      mul_b = BYTE_W'(ftb_i[BYTE_W-1:NIB]);
    end
  end

  assign div_d = (state_q == S_DIV_MTB) ? mtb_dvs_i : BYTE_W'(ftb_i[NIB-1:0]);

  ddr3_serial_mul #(.AW(PW), .BW(BYTE_W)) u_mul (
    .clk_i, .rst_ni, .start_i(mul_start), .a_i(mul_a), .b_i(mul_b),
    .busy_o(mul_busy), .done_o(mul_done), .p_o(mul_p)
  );

  ddr3_serial_div #(.NW(PW), .DW(BYTE_W)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .n_i(mul_p), .d_i(div_d),
    .busy_o(div_busy), .done_o(div_done), .q_o(div_q)
  );

  assign t1_s = $signed({{(TW-PW){1'b0}}, t1_q});
  assign q2_s = $signed({{(TW-PW){1'b0}}, div_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      launched_q <= 1'b0;
      t1_q       <= '0;
      tck_q      <= '0;
    end else begin
      if (mul_start || div_start) launched_q <= 1'b1;
      unique case (state_q)
        S_IDLE: if (go_i) begin
          tck_q      <= '0;
          launched_q <= 1'b0;
          state_q    <= div_ok_o ? S_MUL_NS : S_FIN;
        end
        S_MUL_NS:  if (mul_done) begin state_q <= S_MUL_MTB; launched_q <= 1'b0; end
        S_MUL_MTB: if (mul_done) begin state_q <= S_DIV_MTB; launched_q <= 1'b0; end
        S_DIV_MTB: if (div_done) begin
          t1_q       <= div_q;
          state_q    <= S_MUL_FTB;
          launched_q <= 1'b0;
        end
        S_MUL_FTB: if (mul_done) begin state_q <= S_DIV_FTB; launched_q <= 1'b0; end
        S_DIV_FTB: if (div_done) begin
          tck_q      <= fine_i[BYTE_W-1] ? t1_s - q2_s : t1_s + q2_s;
          state_q    <= S_FIN;
          launched_q <= 1'b0;
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = state_q != S_IDLE;
  assign fin_o  = state_q == S_FIN;
  assign tck_o  = tck_q;

  assert_units_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mul_busy && div_busy));
  assert_fin_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
endmodule

// File: rtl/ddr3_cfg_decoder.sv
module ddr3_cfg_decoder
  import ddr3_dec_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTE_W-1:0]       data_i,
  input  logic                    valid_i,
  input  logic                    end_i,
  output logic signed [TCK_W-1:0] tck_ps_o,
  output logic [CAS_W-1:0]        cas_map_o,
  output logic [CAP_W-1:0]        cap_mib_o,
  output logic                    err_o,
  output logic                    done_o
);
  localparam int unsigned RANK_W = 4;

  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fb;
  logic [NUM_FIELDS-1:0]             seen;
  logic                              busy, fin, div_ok, end_go, missing;
  logic signed [TCK_W-1:0]           seq_tck;
  logic signed [EXP_W-1:0]           cap_exp;
  logic [RANK_W-1:0]                 ranks;
  logic [CAP_W-1:0]                  cap_base, cap_val;
  logic                              unused_bits;

  assign end_go  = end_i && !busy;
  assign missing = !(&seen);

  ddr3_byte_capture #(.N(NUM_FIELDS)) u_cap (
    .clk_i, .rst_ni, .we_i(valid_i && !busy), .clr_i(fin),
    .addr_i, .data_i, .bytes_o(fb), .seen_o(seen)
  );

  ddr3_tck_seq #(.PW(PROD_W), .TW(TCK_W)) u_seq (
    .clk_i, .rst_ni, .go_i(end_go),
    .tck_mtb_i(fb[IDX_TCK]), .fine_i(fb[IDX_FINE]), .ftb_i(fb[IDX_FTB]),
    .mtb_dvd_i(fb[IDX_MTB_DVD]), .mtb_dvs_i(fb[IDX_MTB_DVS]),
    .busy_o(busy), .fin_o(fin), .div_ok_o(div_ok), .tck_o(seq_tck)
  );

  // capacity exponent in MiB: bus width / device width * chip bits / 2^23
  assign cap_exp = $signed({4'b0, fb[IDX_BUSW][2:0]}) - $signed({4'b0, fb[IDX_ORG][2:0]})
                 + $signed({3'b0, fb[IDX_DENS][3:0]}) + 7'sd6;
  assign ranks   = RANK_W'(fb[IDX_ORG][5:3]) + RANK_W'(1);

  always_comb begin
    cap_base = cap_exp[EXP_W-1] ? '0 : (CAP_W'(1) << cap_exp[EXP_W-2:0]);
    cap_val  = '0;
    for (int k = 0; k < RANK_W; k++) begin
      if (ranks[k]) cap_val = cap_val + (cap_base << k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_ps_o  <= '0;
      cas_map_o <= '0;
      cap_mib_o <= '0;
      err_o     <= 1'b0;
      done_o    <= 1'b0;
    end else if (fin) begin
      tck_ps_o  <= div_ok ? seq_tck : '0;
      cas_map_o <= {fb[IDX_CAS_HI][CAS_W-BYTE_W-1:0], fb[IDX_CAS_LO]};
      cap_mib_o <= cap_val;
      err_o     <= missing || !div_ok || cap_exp[EXP_W-1];
      done_o    <= 1'b1;
    end else if (end_go) begin
      done_o    <= 1'b0;
    end
  end

  assign unused_bits = ^{fb[IDX_DENS][7:4], fb[IDX_ORG][7:6], fb[IDX_BUSW][7:3],
                         fb[IDX_CAS_HI][7]};

  assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !end_i |=> done_o);
  assert_out_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(done_o) |-> $stable(tck_ps_o) && $stable(cap_mib_o) && $stable(cas_map_o));
  assert_div_zero_err_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && !div_ok |=> err_o && tck_ps_o == '0);
  assert_cap_zero_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && cap_mib_o == '0 |-> err_o);
  assert_cap_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && cap_mib_o != '0 |-> $countones(cap_mib_o) <= 3);
  assert_missing_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin && missing |=> err_o);
endmodule

// File: tb/ddr3_cfg_decoder_test.sv
module ddr3_cfg_decoder_test;
  import ddr3_dec_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, valid, endp, err, done;
  logic [7:0] addr, data;
  logic signed [TCK_W-1:0] tck;
  logic [CAS_W-1:0] cas;
  logic [CAP_W-1:0] cap;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  ddr3_cfg_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .valid_i(valid),
    .end_i(endp), .tck_ps_o(tck), .cas_map_o(cas), .cap_mib_o(cap),
    .err_o(err), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_of(input int i);
    case (i)
      0: return 8'd4;   1: return 8'd7;   2: return 8'd8;   3: return 8'd9;
      4: return 8'd10;  5: return 8'd11;  6: return 8'd12;  7: return 8'd14;
      8: return 8'd15;  default: return 8'd34;
    endcase
  endfunction

  function automatic logic [7:0] noise_addr();
    case ($urandom % 6)
      0: return 8'd0;  1: return 8'd5;  2: return 8'd13;
      3: return 8'd33; 4: return 8'd35; default: return 8'd200;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; data = d; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse_end();
    endp = 1'b1;
    @(negedge clk);
    endp = 1'b0;
  endtask

  task automatic launch(input logic [9:0][7:0] b, input logic [9:0] pres);
    for (int i = 0; i < 10; i++) begin
      if (pres[i]) wr(addr_of(i), b[i]);
      if ($urandom % 2 == 1) wr(noise_addr(), 8'($urandom));
    end
    pulse_end();
    check(!done, "R9 done drops after end", longint'(done), 0);
  endtask

  task automatic expect_vals(input logic [9:0][7:0] bin, input logic [9:0] pres,
                             output longint e_tck, output longint e_cap,
                             output longint e_cas, output bit e_err);
    logic [9:0][7:0] b;
    int s34, fn, fd, ex;
    bit div0;
    for (int i = 0; i < 10; i++) b[i] = pres[i] ? bin[i] : 8'h00;
    fn = int'(b[3][7:4]);
    fd = int'(b[3][3:0]);
    s34 = int'($signed(b[9]));
    div0 = (fd == 0) || (b[5] == 8'h00);
    if (div0) e_tck = 0;
    else e_tck = (longint'(b[6]) * 1000 * longint'(b[4])) / longint'(b[5])
               + longint'((s34 * fn) / fd);
    ex = int'(b[2][2:0]) - int'(b[1][2:0]) + int'(b[0][3:0]) + 6;
    e_cap = (ex < 0) ? 0 : ((longint'(1) << ex) * (longint'(b[1][5:3]) + 1));
    e_cas = longint'({b[8][6:0], b[7]});
    e_err = (pres != 10'h3FF) || div0 || (ex < 0);
  endtask

  task automatic await_check(input logic [9:0][7:0] b, input logic [9:0] pres,
                             input string err_tag);
    int cyc;
    longint e_tck, e_cap, e_cas;
    bit e_err;
    cyc = 0;
    while (!done && cyc < 128) begin
      @(negedge clk);
      cyc++;
    end
    check(done, "R9 done within 128 cycles", longint'(cyc), 128);
    expect_vals(b, pres, e_tck, e_cap, e_cas, e_err);
    check(longint'(tck) == e_tck, "R3 tck_ps", longint'(tck), e_tck);
    check(longint'(cas) == e_cas, "R5 cas_map", longint'(cas), e_cas);
    check(longint'(cap) == e_cap, "R6 cap_mib", longint'(cap), e_cap);
    check(err == e_err, err_tag, longint'(err), longint'(e_err));
  endtask

  task automatic stream(input logic [9:0][7:0] b, input logic [9:0] pres, input string err_tag);
    launch(b, pres);
    await_check(b, pres, err_tag);
  endtask

  function automatic logic [9:0][7:0] rand_bytes();
    logic [9:0][7:0] b;
    for (int i = 0; i < 10; i++) b[i] = 8'($urandom);
    b[3][3:0] = 4'(1 + $urandom % 15);
    b[4] = 8'(1 + $urandom % 255);
    b[5] = 8'(1 + $urandom % 255);
    return b;
  endfunction

  initial begin
    logic [9:0][7:0] b, keep;
    logic signed [TCK_W-1:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; valid = 1'b0; endp = 1'b0; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    check(!done && !err && tck == 0 && cas == 0 && cap == 0, "R1 outputs in reset",
          longint'(cap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !err && tck == 0 && cap == 0, "R1 outputs after release",
          longint'(done), 0);

    // R3 truncation toward zero with negative fine correction: 1250 - 7
    b = '0;
    b[0] = 8'h02; b[1] = 8'h09; b[2] = 8'h03; b[3] = 8'h52; b[4] = 8'd1; b[5] = 8'd8;
    b[6] = 8'd10; b[7] = 8'hFC; b[8] = 8'h01; b[9] = 8'hFD;
    stream(b, 10'h3FF, "R3 err clear on clean stream");
    check(tck == 28'sd1243, "R3 fine truncation", longint'(tck), 1243);

    // widest product with most negative fine value
    b[3] = 8'hF1; b[4] = 8'd255; b[5] = 8'd1; b[6] = 8'd255; b[9] = 8'h80;
    stream(b, 10'h3FF, "R3 err clear at maximum");
    check(tck == 28'sd65023080, "R3 maximum period", longint'(tck), 65023080);

    // negative result
    b[6] = 8'd0;
    stream(b, 10'h3FF, "R3 err clear negative period");
    check(tck == -28'sd1920, "R3 negative period", longint'(tck), -1920);

    // medium divisor zero
    b = rand_bytes(); b[5] = 8'h00;
    stream(b, 10'h3FF, "R4 err on zero medium divisor");
    check(tck == 0, "R4 tck suppressed", longint'(tck), 0);

    // fine divisor zero
    b = rand_bytes(); b[3][3:0] = 4'h0;
    stream(b, 10'h3FF, "R4 err on zero fine divisor");

    // negative capacity exponent
    b = rand_bytes(); b[0] = 8'hA0; b[1] = 8'h07; b[2] = 8'h00;
    stream(b, 10'h3FF, "R7 err on negative exponent");
    check(cap == 0, "R7 cap zero", longint'(cap), 0);

    // missing bytes 14 and 34
    b = rand_bytes();
    stream(b, 10'h17F, "R8 err on missing bytes");

    // R2 last write wins
    b = rand_bytes();
    wr(8'd12, ~b[6]);
    stream(b, 10'h3FF, "R2 err clear after rewrite");

    // R9 inputs ignored while busy
    b = rand_bytes();
    keep = b;
    launch(b, 10'h3FF);
    repeat (3) @(negedge clk);
    wr(8'd12, ~b[6]);
    wr(8'd11, 8'h00);
    pulse_end();
    await_check(keep, 10'h3FF, "R9 err unaffected by busy writes");
    held = tck;
    repeat (6) @(negedge clk);
    check(done && tck == held, "R9 outputs hold while done", longint'(tck), longint'(held));

    // R10 empty stream after completion
    stream(b, 10'h000, "R10 err on empty stream");
    check(cap == 64, "R10 cap from cleared bytes", longint'(cap), 64);

    for (int n = 0; n < 40; n++) begin
      b = rand_bytes();
      stream(b, 10'h3FF, "R2 err clear with noise writes");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: got %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule